// File: doc/BRIEF.md
# Host Geometry Command Port

This block connects an 8-bit host I/O bus to a drawing engine. The host builds each 16-bit drawing command from two byte writes to a pair of neighbouring port numbers. When the second byte of the pair arrives, the finished word goes into an on-chip command queue that holds 512 words of 16 bits. The drawing engine pops commands from the head of that queue.

One further port number is used in both directions. A read of it returns a status byte: queue almost-full, a frame toggle, a sticky fault, a sticky overflow and queue-empty. A write to it loads a control byte. Bit 7 of that byte holds the geometry section in reset, and writing bit 6 as 1 clears the sticky bits. Two more read ports return saturating collision counters, one for write-pixel hits and one for copy-read-pixel hits. A counter clears itself when the host reads it. Every port access raises its own strobe output for one clock.

A stall watchdog counts status reads that find the queue almost full. It is a state machine with three states:

- `WD_CLEAR`: no streak is running. A status read that sees almost-full moves it to `WD_ARMED` with a run count of 1.
- `WD_ARMED`: a streak is running. A status read that sees almost-full adds one to the count. A status read without almost-full returns it to `WD_CLEAR`. The read that brings the count to `WD_LIMIT` moves it to `WD_TRIPPED`.
- `WD_TRIPPED`: the fault bit is set and the geometry section is held in reset. A control write with bit 6 set returns it to `WD_CLEAR`.

Top module: `geo_cmd_port`

## Requirements
- R1: After a synchronous reset, all six strobes are low, `eng_valid_o` and `geo_rst_o` are low, `ctrl_q_o` is 0, the status byte reads 0x10 (only the empty bit set), and both collision counters read 0.
- R2: A host write is decoded by comparing `host_port_i` with the port parameters. A write to `PORT_HI` (0xF1) or `PORT_LO` (0xF0) loads that byte register and raises its strobe for exactly the following cycle. A write to any other unused port number raises no strobe and pushes nothing.
- R3: With `HI_FIRST`=1, a write to the low port pushes the word {high register, low register} into the queue. The push appears at `eng_cmd_o` with `eng_valid_o`=1 two clock edges after the write cycle. A high-byte write on its own pushes nothing.
- R4: The queue is first-in first-out and holds 512 words. A push while the queue is full and nothing is being popped is dropped and sets status bit 3 (overflow), which is sticky.
- R5: Status bit 0 (almost-full) is 1 exactly when the queue holds 510 or more words.
- R6: Status bit 1 flips on every clock cycle in which `frame_tick_i` is high.
- R7: A status read (host read of `PORT_STAT`, 0xF2) raises `stb_stat_rd_o` for one cycle and places the byte {3'b0, empty, overflow, fault, frame, almost-full} on `host_rdata_o`. The byte is sampled in the read cycle and valid on the following cycle.
- R8: A control write (host write of `PORT_STAT`) raises `stb_ctrl_wr_o` for one cycle and loads `ctrl_q_o`. While bit 7 of the control byte is 1, `geo_rst_o` is 1, the queue is emptied and all pushes are dropped.
- R9: The collision counters are read at `PORT_WCOL` (0xF3) and `PORT_RCOL` (0xF4). Each counts its hit input per cycle and saturates at 255. A read returns the value held before the read and clears the counter. A hit in the same cycle as the read leaves the counter at 1.
- R10: When `WD_LIMIT` (65535) status reads in a row each see almost-full, status bit 2 (fault) is set and `geo_rst_o` is asserted, which empties the queue. A status read without almost-full restarts the count, and reads of other ports do not break the streak.
- R11: A control write with bit 6 set clears both the fault bit and the overflow bit, and it releases the reset that the watchdog holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| host_port_i | input | 8 | Low byte of the host I/O address |
| host_wdata_i | input | 8 | Host write data |
| host_wr_i | input | 1 | One-cycle qualified host write pulse |
| host_rd_i | input | 1 | One-cycle qualified host read pulse |
| host_rdata_o | output | 8 | Registered read data |
| stb_lo_wr_o | output | 1 | Low command byte written |
| stb_hi_wr_o | output | 1 | High command byte written |
| stb_ctrl_wr_o | output | 1 | Control byte written |
| stb_stat_rd_o | output | 1 | Status byte read |
| stb_wcol_rd_o | output | 1 | Write-pixel collision counter read |
| stb_rcol_rd_o | output | 1 | Copy-read collision counter read |
| ctrl_q_o | output | 8 | Last control byte written |
| frame_tick_i | input | 1 | Frame event, toggles status bit 1 |
| wr_hit_i | input | 1 | Write-pixel collision event |
| rd_hit_i | input | 1 | Copy-read-pixel collision event |
| eng_pop_i | input | 1 | Engine takes the head command |
| eng_cmd_o | output | 16 | Head command word |
| eng_valid_o | output | 1 | Queue not empty |
| geo_rst_o | output | 1 | Reset to the geometry section |

## Verification
The assertions assume that the host never raises `host_wr_i` and `host_rd_i` in the same cycle. They also assume that the engine pops only when `eng_valid_o` is high. The bench keeps to both rules because each access task drives exactly one pulse for one cycle and the pop loop depends on `eng_valid_o`. The watchdog properties assume that the status read and the almost-full level are sampled in the same cycle. For that reason the bench always waits one idle cycle after a push before it reads the status port.

// File: rtl/geo_port_pkg.sv
package geo_port_pkg;

    typedef enum logic [1:0] {
        WD_CLEAR   = 2'd0,
        WD_ARMED   = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_t;

    localparam int ST_AFULL = 0;
    localparam int ST_FRAME = 1;
    localparam int ST_FAULT = 2;
    localparam int ST_OVF   = 3;
    localparam int ST_EMPTY = 4;

    localparam int CTRL_CLR_BIT = 6;
    localparam int CTRL_RST_BIT = 7;

endpackage

// File: rtl/geo_cmd_fifo.sv
module geo_cmd_fifo #(
    parameter int DEPTH  = 512,
    parameter int W      = 16,
    parameter int AF_GAP = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         afull_o,
    output logic         ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] AF_LVL   = CW'(DEPTH - AF_GAP);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == FULL_LVL);
    assign afull_o = (cnt_q >= AF_LVL);
    assign rdata_o = mem[rp_q];

    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign do_push = push_i && !flush_i && (!full_o || do_pop);

    always_ff @(posedge clk_i) begin
        if (rst_i || flush_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                                          ovf_o <= 1'b0;
        else if (ovf_clr_i)                                 ovf_o <= 1'b0;
        else if (push_i && !flush_i && full_o && !do_pop)   ovf_o <= 1'b1;
    end

    assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= FULL_LVL);

    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && full_o && !pop_i && !flush_i && !ovf_clr_i) |=> (full_o && ovf_o));

endmodule

// File: rtl/geo_hit_counter.sv
module geo_hit_counter #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] MAXV = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i)                        cnt_o <= '0;
        else if (clr_i)                   cnt_o <= inc_i ? ONE : '0;
        else if (inc_i && cnt_o != MAXV)  cnt_o <= cnt_o + 1'b1;
    end

    assert_clear_on_read_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !inc_i) |=> (cnt_o == '0));

    assert_saturate_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_o == MAXV && !clr_i) |=> (cnt_o == MAXV));

endmodule

// File: rtl/geo_stall_watchdog.sv
module geo_stall_watchdog
    import geo_port_pkg::*;
#(
    parameter int LIMIT = 65535
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stat_evt_i,
    input  logic afull_i,
    input  logic clr_i,
    output logic fault_o
);
    localparam int RW = $clog2(LIMIT + 1);
    localparam logic [RW-1:0] LAST = RW'(LIMIT - 1);
    localparam logic [RW-1:0] ONE  = RW'(1);

    wd_state_t     state_q, state_d;
    logic [RW-1:0] run_q;
    logic          hit;

    assign hit = stat_evt_i && afull_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= WD_CLEAR;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_CLEAR:   if (hit) state_d = (LIMIT == 1) ? WD_TRIPPED : WD_ARMED;
            WD_ARMED: begin
                if (hit && run_q == LAST)        state_d = WD_TRIPPED;
                else if (stat_evt_i && !afull_i) state_d = WD_CLEAR;
            end
            WD_TRIPPED: if (clr_i) state_d = WD_CLEAR;
            default:    state_d = WD_CLEAR;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                               run_q <= '0;
        else if (state_q == WD_CLEAR && hit)     run_q <= ONE;
        else if (state_q == WD_ARMED && hit)     run_q <= run_q + 1'b1;
        else if (state_d == WD_CLEAR)            run_q <= '0;
    end

    assign fault_o = (state_q == WD_TRIPPED);

    assert_trip_cause_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(fault_o) |-> $past(hit));

    assert_fault_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (fault_o && !clr_i) |=> fault_o);

endmodule

// File: rtl/geo_cmd_port.sv
module geo_cmd_port
    import geo_port_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          Q_DEPTH   = 512,
    parameter int          AF_GAP    = 2,
    parameter int          CNT_W     = 8,
    parameter int          WD_LIMIT  = 65535,
    parameter bit          HI_FIRST  = 1'b1,
    parameter logic [7:0]  PORT_LO   = 8'hF0,
    parameter logic [7:0]  PORT_HI   = 8'hF1,
    parameter logic [7:0]  PORT_STAT = 8'hF2,
    parameter logic [7:0]  PORT_WCOL = 8'hF3,
    parameter logic [7:0]  PORT_RCOL = 8'hF4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [7:0]          host_port_i,
    input  logic [DATA_W-1:0]   host_wdata_i,
    input  logic                host_wr_i,
    input  logic                host_rd_i,
    output logic [DATA_W-1:0]   host_rdata_o,
    output logic                stb_lo_wr_o,
    output logic                stb_hi_wr_o,
    output logic                stb_ctrl_wr_o,
    output logic                stb_stat_rd_o,
    output logic                stb_wcol_rd_o,
    output logic                stb_rcol_rd_o,
    output logic [DATA_W-1:0]   ctrl_q_o,
    input  logic                frame_tick_i,
    input  logic                wr_hit_i,
    input  logic                rd_hit_i,
    input  logic                eng_pop_i,
    output logic [2*DATA_W-1:0] eng_cmd_o,
    output logic                eng_valid_o,
    output logic                geo_rst_o
);
    localparam int CMD_W  = 2 * DATA_W;
    localparam int N_CNT  = 2;

    logic [DATA_W-1:0] lo_q, hi_q, status;
    logic wr_lo, wr_hi, wr_ctl, rd_st, rd_wc, rd_rc;
    logic frame_q, push, sticky_clr;
    logic q_empty, q_full, q_afull, q_ovf, wd_fault;
    logic [N_CNT-1:0]  cnt_inc, cnt_clr;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    // host decode
    assign wr_lo  = host_wr_i && (host_port_i == PORT_LO);
    assign wr_hi  = host_wr_i && (host_port_i == PORT_HI);
    assign wr_ctl = host_wr_i && (host_port_i == PORT_STAT);
    assign rd_st  = host_rd_i && (host_port_i == PORT_STAT);
    assign rd_wc  = host_rd_i && (host_port_i == PORT_WCOL);
    assign rd_rc  = host_rd_i && (host_port_i == PORT_RCOL);
    assign sticky_clr = wr_ctl && host_wdata_i[CTRL_CLR_BIT];

    // byte registers and strobes: data and strobe valid on the same edge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q          <= '0;
            hi_q          <= '0;
            ctrl_q_o      <= '0;
            stb_lo_wr_o   <= 1'b0;
            stb_hi_wr_o   <= 1'b0;
            stb_ctrl_wr_o <= 1'b0;
        end else begin
            if (wr_lo) begin
                lo_q        <= host_wdata_i;
                stb_lo_wr_o <= 1'b1;
            end else stb_lo_wr_o <= 1'b0;

            if (wr_hi) begin
                hi_q        <= host_wdata_i;
                stb_hi_wr_o <= 1'b1;
            end else stb_hi_wr_o <= 1'b0;

            if (wr_ctl) begin
                ctrl_q_o      <= host_wdata_i;
                stb_ctrl_wr_o <= 1'b1;
            end else stb_ctrl_wr_o <= 1'b0;
        end
    end

    // status byte
    always_comb begin
        status           = '0;
        status[ST_AFULL] = q_afull;
        status[ST_FRAME] = frame_q;
        status[ST_FAULT] = wd_fault;
        status[ST_OVF]   = q_ovf;
        status[ST_EMPTY] = q_empty;
    end

    // read data and read strobes
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            host_rdata_o  <= '0;
            stb_stat_rd_o <= 1'b0;
            stb_wcol_rd_o <= 1'b0;
            stb_rcol_rd_o <= 1'b0;
            frame_q       <= 1'b0;
        end else begin
            stb_stat_rd_o <= rd_st;
            stb_wcol_rd_o <= rd_wc;
            stb_rcol_rd_o <= rd_rc;
            if (rd_st)      host_rdata_o <= status;
            else if (rd_wc) host_rdata_o <= DATA_W'(cnt_val[0]);
            else if (rd_rc) host_rdata_o <= DATA_W'(cnt_val[1]);
            if (frame_tick_i) frame_q <= !frame_q;
        end
    end

    // which byte completes a word
    generate
        if (HI_FIRST) begin : g_push_on_lo
            assign push = stb_lo_wr_o;
        end else begin : g_push_on_hi
            assign push = stb_hi_wr_o;
        end
    endgenerate

    // collision counters, cleared by their own read
    assign cnt_inc = {rd_hit_i, wr_hit_i};
    assign cnt_clr = {rd_rc, rd_wc};

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            geo_hit_counter #(.CW(CNT_W)) u_cnt (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .inc_i (cnt_inc[g]),
                .clr_i (cnt_clr[g]),
                .cnt_o (cnt_val[g])
            );
        end
    endgenerate

    geo_cmd_fifo #(.DEPTH(Q_DEPTH), .W(CMD_W), .AF_GAP(AF_GAP)) u_fifo (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .flush_i   (geo_rst_o),
        .push_i    (push),
        .wdata_i   ({hi_q, lo_q}),
        .pop_i     (eng_pop_i),
        .ovf_clr_i (sticky_clr),
        .rdata_o   (eng_cmd_o),
        .empty_o   (q_empty),
        .full_o    (q_full),
        .afull_o   (q_afull),
        .ovf_o     (q_ovf)
    );

    geo_stall_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stat_evt_i (rd_st),
        .afull_i    (q_afull),
        .clr_i      (sticky_clr),
        .fault_o    (wd_fault)
    );

    assign eng_valid_o = !q_empty;
    assign geo_rst_o   = ctrl_q_o[CTRL_RST_BIT] || wd_fault;

    assert_lo_capture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_lo_wr_o |-> (lo_q == $past(host_wdata_i)));

    assert_push_lands_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (push && !geo_rst_o) |=> eng_valid_o);

    assert_rst_flush_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        geo_rst_o |=> !eng_valid_o);

    assert_no_full_drop_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !(q_full && !q_afull));

endmodule

// File: tb/sim_geo_cmd_port.sv
module sim_geo_cmd_port;
    localparam logic [7:0] P_LO = 8'hF0, P_HI = 8'hF1, P_ST = 8'hF2,
                           P_WC = 8'hF3, P_RC = 8'hF4;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] host_port = '0, host_wdata = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic frame_tick = 1'b0, wr_hit = 1'b0, rd_hit = 1'b0, eng_pop = 1'b0;
    logic [7:0]  host_rdata, ctrl_q;
    logic stb_lo, stb_hi, stb_ctl, stb_st, stb_wc, stb_rc;
    logic [15:0] eng_cmd;
    logic eng_valid, geo_rst;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    geo_cmd_port u0 (
        .clk_i(clk), .rst_i(rst), .host_port_i(host_port), .host_wdata_i(host_wdata),
        .host_wr_i(host_wr), .host_rd_i(host_rd), .host_rdata_o(host_rdata),
        .stb_lo_wr_o(stb_lo), .stb_hi_wr_o(stb_hi), .stb_ctrl_wr_o(stb_ctl),
        .stb_stat_rd_o(stb_st), .stb_wcol_rd_o(stb_wc), .stb_rcol_rd_o(stb_rc),
        .ctrl_q_o(ctrl_q), .frame_tick_i(frame_tick), .wr_hit_i(wr_hit),
        .rd_hit_i(rd_hit), .eng_pop_i(eng_pop), .eng_cmd_o(eng_cmd),
        .eng_valid_o(eng_valid), .geo_rst_o(geo_rst)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] p, logic [7:0] d);
        host_port = p; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] p, output logic [7:0] v);
        host_port = p; host_rd = 1'b1;
        @(negedge clk);
        v = host_rdata; host_rd = 1'b0;
    endtask

    task automatic push_word(logic [15:0] w);
        wr(P_HI, w[15:8]);
        wr(P_LO, w[7:0]);
        @(negedge clk);
    endtask

    task automatic pop1();
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (eng_valid) begin pop1(); n++; end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 strobes", {stb_lo, stb_hi, stb_ctl, stb_st, stb_wc, stb_rc}, 0);
        check("R1 valid/rst/ctrl", {eng_valid, geo_rst, ctrl_q}, 0);
        rd(P_ST, v);  check("R1 status", v, 8'h10);
        rd(P_WC, v);  check("R1 wcol", v, 0);
        rd(P_RC, v);  check("R1 rcol", v, 0);
    endtask

    task automatic t_pair();
        wr(P_HI, 8'hAB);
        check("R2 hi strobe", {stb_hi, stb_lo}, 2'b10);
        @(negedge clk);
        check("R3 hi alone no push", eng_valid, 0);
        check("R2 strobe one cycle", stb_hi, 0);
        wr(P_LO, 8'hCD);
        check("R2 lo strobe", {stb_hi, stb_lo}, 2'b01);
        @(negedge clk);
        check("R3 word valid", eng_valid, 1);
        check("R3 word value", eng_cmd, 16'hABCD);
        pop1();
        wr(8'h55, 8'h99);
        check("R2 unused port strobes", {stb_lo, stb_hi, stb_ctl}, 0);
        @(negedge clk);
        check("R2 unused port no push", eng_valid, 0);
        wr(P_LO, 8'h11);
        @(negedge clk);
        check("R3 high byte kept", eng_cmd, 16'hAB11);
        pop1();
    endtask

    task automatic t_order();
        int n;
        push_word(16'h1111); push_word(16'h2222); push_word(16'h3333);
        check("R4 head 1", eng_cmd, 16'h1111); pop1();
        check("R4 head 2", eng_cmd, 16'h2222); pop1();
        check("R4 head 3", eng_cmd, 16'h3333);
        drain(n);
        check("R4 empty after", eng_valid, 0);
    endtask

    task automatic t_frame();
        logic [7:0] v;
        rd(P_ST, v); check("R6 frame start", v[1], 0);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        rd(P_ST, v); check("R6 frame flip", v[1], 1);
        check("R7 stat strobe", stb_st, 1);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        rd(P_ST, v); check("R6 frame back", v[1], 0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        for (int i = 0; i < 3; i++) begin wr_hit = 1'b1; @(negedge clk); wr_hit = 1'b0; @(negedge clk); end
        rd(P_WC, v); check("R9 wcol count", v, 3);
        check("R9 wcol strobe", stb_wc, 1);
        rd(P_WC, v); check("R9 wcol cleared", v, 0);
        rd_hit = 1'b1; repeat (300) @(negedge clk); rd_hit = 1'b0;
        rd(P_RC, v); check("R9 rcol saturate", v, 255);
        check("R9 rcol strobe", stb_rc, 1);
        wr_hit = 1'b1; repeat (2) @(negedge clk);
        rd(P_WC, v); wr_hit = 1'b0;
        check("R9 read with hit", v, 2);
        rd(P_WC, v); check("R9 hit kept after clear", v, 1);
    endtask

    task automatic t_ctrl();
        push_word(16'h4242);
        wr(P_ST, 8'h80);
        check("R8 ctrl strobe", stb_ctl, 1);
        check("R8 ctrl value", ctrl_q, 8'h80);
        check("R8 geo reset", geo_rst, 1);
        @(negedge clk);
        check("R8 flushed", eng_valid, 0);
        push_word(16'h5151);
        check("R8 push dropped", eng_valid, 0);
        wr(P_ST, 8'h00);
        check("R8 reset released", geo_rst, 0);
    endtask

    task automatic t_full();
        logic [7:0] v;
        int n, bad;
        for (int i = 0; i < 509; i++) push_word(16'(i));
        rd(P_ST, v); check("R5 509 not afull", v[0], 0);
        push_word(16'd509);
        rd(P_ST, v); check("R5 510 afull", v[0], 1);
        push_word(16'd510); push_word(16'd511);
        rd(P_ST, v); check("R4 full no ovf", v[3], 0);
        push_word(16'hFFFF);
        rd(P_ST, v); check("R4 overflow bit", v[3], 1);
        bad = 0; n = 0;
        while (eng_valid) begin
            if (eng_cmd != 16'(n)) bad++;
            pop1(); n++;
        end
        check("R4 depth", n, 512);
        check("R4 order kept", bad, 0);
        wr(P_ST, 8'h40);
        rd(P_ST, v); check("R11 ovf cleared", v, 8'h10);
    endtask

    task automatic t_watchdog();
        logic [7:0] v;
        int seen;
        for (int i = 0; i < 510; i++) push_word(16'(i));
        seen = 0;
        for (int i = 0; i < 65534; i++) begin rd(P_ST, v); if (v[2]) seen++; end
        check("R10 no trip before limit", {seen[7:0], 7'b0, geo_rst}, 0);
        pop1();
        rd(P_ST, v); check("R10 streak broken", v[0], 0);
        push_word(16'hAAAA);
        seen = 0;
        for (int i = 0; i < 65534; i++) begin rd(P_ST, v); if (v[2]) seen++; end
        check("R10 count restarted", {seen[7:0], 7'b0, geo_rst}, 0);
        rd(P_WC, v);
        rd(P_ST, v);
        check("R10 trip", geo_rst, 1);
        @(negedge clk);
        check("R10 queue flushed", eng_valid, 0);
        rd(P_ST, v); check("R10 fault status", v, 8'h14);
        wr(P_ST, 8'h40);
        check("R11 fault cleared", geo_rst, 0);
        rd(P_ST, v); check("R11 status clean", v, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pair();
        t_order();
        t_frame();
        t_collide();
        t_ctrl();
        t_full();
        t_watchdog();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule